// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of one SDR SDRAM rank from reset onward. It first raises clock enable with the bus idle and holds off every other command for a programmable settling window. It then runs a fixed start-up script: one precharge of all banks, two auto-refresh steps of several back-to-back refreshes each, and one mode-register load. After that it signals that the device is ready.

Once ready, a free-running down-counter asks for an auto-refresh at a fixed reload interval. A single arbitration input lets an external traffic source hold the refresh back. Expiries that arrive while the refresh is held back merge into one outstanding refresh, which is issued as soon as the input goes low. Every command spacing, the start-up window, the refresh count per step, the mode-register fields and the refresh interval are parameters.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst` is high, `cke` is low, `cs_n`, `ras_n`, `cas_n` and `we_n` are high, and `init_done` and `busy` are low.
- R2: After reset is released, `cke` rises with a NOP on the bus. The first command is precharge-all, coded as {cs_n,ras_n,cas_n,we_n} = 0,0,1,0 with `addr[10]` high. It appears exactly `STARTUP_CYC` cycles after the first cycle with `cke` high.
- R3: The start-up script contains `INIT_REF_STEPS` x `REFS_PER_STEP` auto-refresh commands (default 2 x 4 = 8), each coded as 0,0,0,1. The first comes `T_RP` cycles after the precharge, and each of the others comes `T_RC` cycles after the one before it.
- R4: The load-mode command (0,0,0,0) comes `T_RC` cycles after the last start-up refresh, with `ba` = 0. With the defaults, `addr` = 0x231: bits [2:0] = 001 (burst of 2), bit 3 = 0 (sequential), bits [6:4] = 011 (CAS latency 3), bits [8:7] = 00 (standard mode), bit 9 = 1 (single-location writes), and the remaining bits are 0.
- R5: `init_done` rises exactly `T_MRD` cycles after the load-mode command and stays high until the next reset.
- R6: In every cycle with `cke` high that carries no command, the bus shows a NOP (0,1,1,1). No command other than precharge-all, auto-refresh and load-mode is ever issued.
- R7: While `ext_req` stays low, periodic auto-refreshes appear `REFRESH_RELOAD` cycles after `init_done` rises and every `REFRESH_RELOAD` cycles after that.
- R8: No periodic refresh appears in a cycle that follows a clock edge at which `ext_req` was high. If one or more expiries occur while `ext_req` is high, exactly one refresh appears in the cycle after the first edge that samples `ext_req` low. The following refresh then keeps to the original interval grid.
- R9: `busy` is high from the cycle in which a command (or the clock-enable step) appears for that step's spacing minus one cycles, and low otherwise. A new command is issued only when `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 1 | High while external traffic needs the bus; holds back refresh |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Address bus |
| init_done | output | 1 | High once the start-up script has completed |
| busy | output | 1 | High while a command spacing window is open |

## Verification
All pins are registered, so a command decided at a clock edge shows on the bus in the next cycle. Every spacing is therefore an exact cycle distance between two bus commands. The bench samples at the falling edge, gives each cycle an index, and logs each command with its index. It compares each logged index with a sum of parameters taken from the requirements. For example, a refresh released by `ext_req` going low is due one cycle after the edge that samples the drop. `busy` is predicted in every cycle from the last command index and that command's spacing.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NORMAL   = 3'd0,
    CMD_CLK_EN   = 3'd1,
    CMD_PRE_ALL  = 3'd2,
    CMD_AUTO_REF = 3'd3,
    CMD_LOAD_MR  = 3'd4,
    CMD_SELF_REF = 3'd5,
    CMD_PWR_DOWN = 3'd6
  } seq_cmd_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Mode word: [2:0] burst code, [3] interleave, [6:4] CAS, [8:7] op mode, [9] single write
  function automatic logic [15:0] build_mode_word(input int burst_code, input bit interleave,
                                                  input int cas, input bit single_wr);
    logic [15:0] w;
    w        = '0;
    w[2:0]   = 3'(burst_code);
    w[3]     = interleave;
    w[6:4]   = 3'(cas);
    w[8:7]   = 2'b00;
    w[9]     = single_wr;
    return w;
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GAP_W-1:0] spacing,
  output logic             idle
);
  logic [GAP_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (load)          remain <= spacing - 1'b1;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign idle = (remain == '0);

  // R9: a new spacing window opens only once the previous one has closed
  assert_load_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    load |-> idle);

  // R9: an open window shrinks by one every cycle
  assert_window_shrinks_R9: assert property (@(posedge clk) disable iff (rst)
    (!idle && !load) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int RELOAD = 683
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic taken,
  output logic want
);
  localparam int CW = $clog2(RELOAD + 1);
  localparam logic [CW-1:0] RELOAD_M1 = CW'(RELOAD - 1);

  logic [CW-1:0] cnt;
  logic          armed;
  logic          pending;
  logic          expire;

  assign expire = armed && (cnt == '0);
  assign want   = expire || pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      armed   <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (start) begin
        cnt   <= RELOAD_M1;
        armed <= 1'b1;
      end else if (armed) begin
        cnt <= expire ? RELOAD_M1 : cnt - 1'b1;
      end
      pending <= want && !taken;
    end
  end

  // R8: a held-back request survives until it is served
  assert_pending_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (want && !taken) |=> want);

  // R7: the refresh grid restarts at the full interval after each expiry
  assert_reload_after_expiry_R7: assert property (@(posedge clk) disable iff (rst)
    (expire && !start) |=> (cnt == RELOAD_M1));
endmodule

// File: rtl/sdram_pin_driver.sv
module sdram_pin_driver
  import sdram_seq_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          BA_W      = 2,
  parameter logic [15:0] MODE_WORD = 16'h0231
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  seq_cmd_e          cmd,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);
  logic              cke_nxt;
  logic [2:0]        rcw_nxt;
  logic [ADDR_W-1:0] addr_nxt;

  always_comb begin
    cke_nxt  = cke || (issue && cmd == CMD_CLK_EN);
    rcw_nxt  = 3'b111;
    addr_nxt = '0;
    if (issue) begin
      case (cmd)
        CMD_PRE_ALL:  begin rcw_nxt = 3'b010; addr_nxt[10] = 1'b1; end
        CMD_AUTO_REF: rcw_nxt = 3'b001;
        CMD_LOAD_MR:  begin rcw_nxt = 3'b000; addr_nxt = MODE_WORD[ADDR_W-1:0]; end
        default:      rcw_nxt = 3'b111;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke   <= 1'b0;
      cs_n  <= 1'b1;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      ba    <= '0;
      addr  <= '0;
    end else begin
      cke   <= cke_nxt;
      cs_n  <= !cke_nxt;
      {ras_n, cas_n, we_n} <= rcw_nxt;
      ba    <= '0;
      addr  <= addr_nxt;
    end
  end
endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_BITS       = 12,
  parameter int BANKS          = 4,
  parameter int STARTUP_CYC    = 9000,
  parameter int T_RP           = 2,
  parameter int T_RC           = 7,
  parameter int T_MRD          = 2,
  parameter int INIT_REF_STEPS = 2,
  parameter int REFS_PER_STEP  = 4,
  parameter int REFRESH_RELOAD = 683,
  parameter int BURST_CODE     = 1,
  parameter bit BURST_INTLV    = 1'b0,
  parameter int CAS_LAT        = 3,
  parameter bit SINGLE_WRITE   = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ext_req,
  output logic                cke,
  output logic                cs_n,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [$clog2(BANKS)-1:0] ba,
  output logic [ROW_BITS-1:0] addr,
  output logic                init_done,
  output logic                busy
);
  localparam int BA_W       = $clog2(BANKS);
  localparam int INIT_REFS  = INIT_REF_STEPS * REFS_PER_STEP;
  localparam int IDX_W      = $clog2(INIT_REFS + 1);
  localparam int MAX_GAP    = max_of(max_of(STARTUP_CYC, T_RC), max_of(T_RP, T_MRD));
  localparam int GAP_W      = $clog2(MAX_GAP + 1);
  localparam logic [15:0] MODE_WORD =
    build_mode_word(BURST_CODE, BURST_INTLV, CAS_LAT, SINGLE_WRITE);

  typedef enum logic [2:0] {
    ST_CKE, ST_PALL, ST_IREF, ST_LMR, ST_FIN, ST_RUN
  } seq_state_e;

  seq_state_e       state, state_nxt;
  logic [IDX_W-1:0] ref_idx;
  logic             issue;
  seq_cmd_e         cmd;
  logic [GAP_W-1:0] spacing;
  logic             gap_idle;
  logic             ref_want;
  logic             ref_taken;
  logic             fin;

  always_comb begin
    state_nxt = state;
    issue     = 1'b0;
    cmd       = CMD_NORMAL;
    spacing   = '0;
    fin       = 1'b0;
    ref_taken = 1'b0;
    if (gap_idle) begin
      case (state)
        ST_CKE: begin
          issue = 1'b1; cmd = CMD_CLK_EN; spacing = GAP_W'(STARTUP_CYC);
          state_nxt = ST_PALL;
        end
        ST_PALL: begin
          issue = 1'b1; cmd = CMD_PRE_ALL; spacing = GAP_W'(T_RP);
          state_nxt = ST_IREF;
        end
        ST_IREF: begin
          issue = 1'b1; cmd = CMD_AUTO_REF; spacing = GAP_W'(T_RC);
          if (ref_idx == IDX_W'(INIT_REFS - 1)) state_nxt = ST_LMR;
        end
        ST_LMR: begin
          issue = 1'b1; cmd = CMD_LOAD_MR; spacing = GAP_W'(T_MRD);
          state_nxt = ST_FIN;
        end
        ST_FIN: begin
          fin = 1'b1;
          state_nxt = ST_RUN;
        end
        default: begin
          if (ref_want && !ext_req) begin
            issue = 1'b1; cmd = CMD_AUTO_REF; spacing = GAP_W'(T_RC);
            ref_taken = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CKE;
      ref_idx   <= '0;
      init_done <= 1'b0;
    end else begin
      state <= state_nxt;
      if (issue && state == ST_IREF) ref_idx <= ref_idx + 1'b1;
      if (fin) init_done <= 1'b1;
    end
  end

  sdram_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst(rst), .load(issue), .spacing(spacing), .idle(gap_idle)
  );

  sdram_refresh_timer #(.RELOAD(REFRESH_RELOAD)) u_refresh (
    .clk(clk), .rst(rst), .start(fin), .taken(ref_taken), .want(ref_want)
  );

  sdram_pin_driver #(.ADDR_W(ROW_BITS), .BA_W(BA_W), .MODE_WORD(MODE_WORD)) u_pins (
    .clk(clk), .rst(rst), .issue(issue), .cmd(cmd),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr)
  );

  assign busy = !gap_idle;

  // R2: precharge-all always carries A10 high
  assert_pall_a10_R2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && cas_n && !we_n) |-> addr[10]);

  // R4: load-mode carries the parameter-built word on bank 0
  assert_mode_word_R4: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ras_n && !cas_n && !we_n) |-> (addr == MODE_WORD[ROW_BITS-1:0] && ba == '0));

  // R5: once ready, stays ready
  assert_ready_sticks_R5: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R6: the device is selected only with its clock enabled
  assert_select_needs_cke_R6: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> cke);

  // R8: a periodic refresh never follows an edge that saw ext_req high
  assert_defer_honoured_R8: assert property (@(posedge clk) disable iff (rst)
    (init_done && $past(init_done) && !cs_n && !ras_n && !cas_n && we_n) |-> !$past(ext_req));
endmodule

// File: tb/tb_sdram_powerup_seq.sv
module tb_sdram_powerup_seq;
  localparam int S   = 20;
  localparam int TRP = 2;
  localparam int TRC = 7;
  localparam int TMR = 2;
  localparam int RL  = 40;
  localparam int NREF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_req = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, busy;
  logic [1:0]  ba;
  logic [11:0] addr;

  always #4 clk = ~clk;

  sdram_powerup_seq #(
    .STARTUP_CYC(S), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMR), .REFRESH_RELOAD(RL)
  ) dut (
    .clk(clk), .rst(rst), .ext_req(ext_req), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  int cyc = 0;
  int k_cyc = -1;
  int d_cyc = -1;
  int last_cmd = -100000;
  int last_sp = 0;
  int ev_n = 0;
  int ev_cyc [64];
  int ev_kind [64];
  int ev_addr [64];
  int ev_ba [64];
  int bad_pat = 0;
  int busy_err = 0;
  int ready_drop = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: one index per cycle, sampled at the falling edge
  always @(negedge clk) begin
    int kind;
    cyc = cyc + 1;
    if (!rst) begin
      kind = 0;
      if (cke && k_cyc < 0) begin
        k_cyc = cyc; last_cmd = cyc; last_sp = S;
      end
      if (cke) begin
        if (cs_n) bad_pat++;
        else case ({ras_n, cas_n, we_n})
          3'b111: kind = 0;
          3'b010: kind = 2;
          3'b001: kind = 3;
          3'b000: kind = 4;
          default: bad_pat++;
        endcase
      end else if (!cs_n) bad_pat++;
      if (kind != 0) begin
        if (ev_n < 64) begin
          ev_cyc[ev_n] = cyc; ev_kind[ev_n] = kind;
          ev_addr[ev_n] = int'(addr); ev_ba[ev_n] = int'(ba);
        end
        ev_n++;
        last_cmd = cyc;
        last_sp = (kind == 2) ? TRP : (kind == 4) ? TMR : TRC;
      end
      if (busy !== ((cyc - last_cmd) < (last_sp - 1))) busy_err++;
      if (init_done && d_cyc < 0) d_cyc = cyc;
      if (d_cyc >= 0 && !init_done) ready_drop++;
    end
  end

  task automatic wait_cyc(input int target);
    do begin @(negedge clk); #2; end while (cyc < target);
  endtask

  initial begin
    int e;
    int d;
    repeat (4) @(posedge clk);
    @(negedge clk); #2;
    // R1: reset values
    check(cke == 1'b0 && cs_n && ras_n && cas_n && we_n, "R1 pins in reset",
          int'({cke, cs_n, ras_n, cas_n, we_n}), 5'b01111);
    check(!init_done && !busy, "R1 flags in reset", int'({init_done, busy}), 0);
    rst = 1'b0;
    while (d_cyc < 0) begin @(negedge clk); #2; end
    d = d_cyc;
    wait_cyc(d + 3*RL + 5);
    ext_req = 1'b1;
    wait_cyc(d + 6*RL + 9);
    ext_req = 1'b0;
    wait_cyc(d + 8*RL + 5);

    // R2: precharge-all timing and A10
    check(ev_kind[0] == 2, "R2 first command kind", ev_kind[0], 2);
    check(ev_cyc[0] == k_cyc + S, "R2 precharge cycle", ev_cyc[0], k_cyc + S);
    check(ev_addr[0][10] == 1'b1, "R2 A10", ev_addr[0], 1024);
    // R3: start-up refreshes
    e = ev_cyc[0] + TRP;
    for (int i = 1; i <= NREF; i++) begin
      check(ev_kind[i] == 3, "R3 refresh kind", ev_kind[i], 3);
      check(ev_cyc[i] == e, "R3 refresh cycle", ev_cyc[i], e);
      e = e + TRC;
    end
    // R4: load-mode
    check(ev_kind[NREF+1] == 4, "R4 load-mode kind", ev_kind[NREF+1], 4);
    check(ev_cyc[NREF+1] == e, "R4 load-mode cycle", ev_cyc[NREF+1], e);
    check(ev_addr[NREF+1] == 'h231, "R4 mode word", ev_addr[NREF+1], 'h231);
    check(ev_ba[NREF+1] == 0, "R4 bank", ev_ba[NREF+1], 0);
    // R5: ready timing and stickiness
    check(d == e + TMR, "R5 init_done rise", d, e + TMR);
    check(ready_drop == 0, "R5 init_done held", ready_drop, 0);
    // R7: periodic refreshes
    for (int k = 1; k <= 3; k++) begin
      check(ev_kind[NREF+1+k] == 3 && ev_cyc[NREF+1+k] == d + k*RL, "R7 periodic refresh",
            ev_cyc[NREF+1+k], d + k*RL);
    end
    // R8: deferral, merge and grid
    check(ev_cyc[NREF+5] == d + 6*RL + 10, "R8 deferred refresh", ev_cyc[NREF+5], d + 6*RL + 10);
    check(ev_cyc[NREF+6] == d + 7*RL, "R8 grid after deferral", ev_cyc[NREF+6], d + 7*RL);
    check(ev_cyc[NREF+7] == d + 8*RL, "R7 steady refresh", ev_cyc[NREF+7], d + 8*RL);
    check(ev_n == NREF + 8, "R8 merged expiries event count", ev_n, NREF + 8);
    // R6, R9: every-cycle observations
    check(bad_pat == 0, "R6 bus patterns", bad_pat, 0);
    check(busy_err == 0, "R9 busy window", busy_err, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule